// File: doc/BRIEF.md
# FSK Delay-Line Discriminator

This block makes a hard tone decision for every incoming audio sample of a two-tone FSK receiver running at 9600 samples per second with 8 samples per bit. Each new signed 8-bit sample is multiplied by the sample taken half a bit period (4 samples) earlier. The product is scaled down and smoothed by a first-order low-pass IIR filter with a corner near 600 Hz. The sign of the smoothed value is then pushed into an 8-bit history register.

Downstream logic, such as a bit-clock recovery loop, reads the history register and its newest bit. The single-multiplier correlation depends only on phase rotation over a fixed delay, so it replaces a pair of tone-selective bandpass filters. After reset the block stays silent until it holds enough past samples to form a product.

Top module: `fsk_discriminator`

## Requirements
- R1: After reset asserted on a clock edge, `bits_out` and `bit_now` are 0 and the filter history is zero. Reset takes priority over a sample strobe in the same cycle.
- R2: In a cycle where `sample_valid` is low, `bits_out` and `bit_now` keep their values.
- R3: After reset, the first 4 strobed samples only fill the delay line. `bits_out` does not shift for them and stays 0.
- R4: From the 5th strobe after reset onward, the filter input for strobe n is x[n] = (s[n] * s[n-4]) arithmetically shifted right by 2, where s is the signed sample sequence counted in strobes.
- R5: The filter output is y[n] = sat16(t>>>3 + t>>>5 + t>>>7 + y[n-1]>>>1 + y[n-1]>>>3 + y[n-1]>>>5 + y[n-1]>>>6), with t = x[n] + x[n-1]. Each shift is an arithmetic (floor) shift applied separately, and x and y start at 0 after reset.
- R6: On each filtered strobe, `bits_out` shifts left by one, and bit 0 takes 1 when y[n] > 0 and 0 otherwise. The new value is visible in the cycle after the strobe.
- R7: `bit_now` always equals bit 0 of `bits_out`.
- R8: Suppose the input repeats every 4 samples with nonzero values. After 8 filtered strobes `bits_out` is 8'hFF. Suppose it then flips sign every 4 samples. After 16 further strobes `bits_out` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Strobe marking a new sample on `sample_in` |
| sample_in | input | 8 | Signed two's-complement audio sample |
| bits_out | output | 8 | History of sign decisions, newest in bit 0 |
| bit_now | output | 1 | Newest decision (bit 0 of `bits_out`) |

## Verification
Two events can land in the same cycle: a sample strobe together with reset, and the last fill strobe directly followed by the first filtered strobe. The bench raises reset in the same cycle as a strobe at several points in a random run. It checks that the history reads zero and that the next four strobes again leave it untouched. Back-to-back strobes across the fill boundary are compared step by step with a bench model of the correlation and filter arithmetic.

// File: rtl/fsk_disc_pkg.sv
package fsk_disc_pkg;
  localparam int HIST_W  = 16;
  localparam int GUARD_W = 4;
  localparam int PROD_SH = 2;
  localparam int A_TERMS = 3;
  localparam int B_TERMS = 4;
  localparam int A_SH [A_TERMS] = '{3, 5, 7};
  localparam int B_SH [B_TERMS] = '{1, 3, 5, 6};
endpackage

// File: rtl/fsk_delay_line.sv
module fsk_delay_line #(
  parameter int W     = 8,
  parameter int DELAY = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] oldest,
  output logic                full
);
  localparam int CNT_W = $clog2(DELAY + 1);

  logic signed [W-1:0] tap [DELAY];
  logic [CNT_W-1:0]    fill_cnt;

  always_ff @(posedge clk) begin
    if (push) tap[0] <= din;
  end

  genvar i;
  generate
    for (i = 1; i < DELAY; i++) begin : g_tap
      always_ff @(posedge clk) begin
        if (push) tap[i] <= tap[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) fill_cnt <= '0;
    else if (push && fill_cnt != CNT_W'(DELAY)) fill_cnt <= fill_cnt + 1'b1;
  end

  assign oldest = tap[DELAY-1];
  assign full   = (fill_cnt == CNT_W'(DELAY));
endmodule

// File: rtl/fsk_lpf_iir.sv
module fsk_lpf_iir
  import fsk_disc_pkg::*;
#(
  parameter int W = HIST_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] x_in,
  output logic signed [W-1:0] y_next
);
  localparam int EW = W + GUARD_W;
  localparam logic signed [EW-1:0] HI = EW'(2**(W-1) - 1);
  localparam logic signed [EW-1:0] LO = -HI - EW'(1);

  logic signed [W-1:0]  x_hist, y_hist;
  logic signed [EW-1:0] sum_e, yh_e, acc;

  always_comb begin
    sum_e = EW'(x_in) + EW'(x_hist);
    yh_e  = EW'(y_hist);
    acc   = '0;
    for (int k = 0; k < A_TERMS; k++) acc = acc + (sum_e >>> A_SH[k]);
    for (int k = 0; k < B_TERMS; k++) acc = acc + (yh_e >>> B_SH[k]);
    if (acc > HI)      y_next = HI[W-1:0];
    else if (acc < LO) y_next = LO[W-1:0];
    else               y_next = acc[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_hist <= '0;
      y_hist <= '0;
    end else if (en) begin
      x_hist <= x_in;
      y_hist <= y_next;
    end
  end
endmodule

// File: rtl/fsk_discriminator.sv
module fsk_discriminator
  import fsk_disc_pkg::*;
#(
  parameter int SAMPLE_W        = 8,
  parameter int SAMPLES_PER_BIT = 8,
  parameter int BITS_W          = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sample_valid,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  output logic [BITS_W-1:0]          bits_out,
  output logic                       bit_now
);
  localparam int DEPTH  = SAMPLES_PER_BIT / 2 + 1;
  localparam int DELAY  = DEPTH - 1;
  localparam int PROD_W = 2 * SAMPLE_W;

  logic signed [SAMPLE_W-1:0] delayed;
  logic                       line_full;
  logic signed [PROD_W-1:0]   product;
  logic signed [HIST_W-1:0]   x_scaled, y_new;
  logic                       filt_en;

  fsk_delay_line #(.W(SAMPLE_W), .DELAY(DELAY)) u_line (
    .clk(clk), .rst(rst), .push(sample_valid), .din(sample_in),
    .oldest(delayed), .full(line_full)
  );

  assign product  = sample_in * delayed;
  assign x_scaled = HIST_W'(product >>> PROD_SH);
  assign filt_en  = sample_valid && line_full;

  fsk_lpf_iir #(.W(HIST_W)) u_lpf (
    .clk(clk), .rst(rst), .en(filt_en), .x_in(x_scaled), .y_next(y_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_out <= '0;
      bit_now  <= 1'b0;
    end else if (filt_en) begin
      bits_out <= {bits_out[BITS_W-2:0], (y_new > 0)};
      bit_now  <= (y_new > 0);
    end
  end
endmodule

// File: rtl/fsk_disc_checker.sv
module fsk_disc_checker #(
  parameter int BITS_W = 8,
  parameter int DELAY  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              valid,
  input logic [BITS_W-1:0] bits,
  input logic              bit_now
);
  localparam int CW = $clog2(DELAY + 1);
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (valid && seen != CW'(DELAY)) seen <= seen + 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (bits == '0 && !bit_now)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(bits) && $stable(bit_now))); // R2
  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (valid && seen != CW'(DELAY)) |=> bits == '0); // R3
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
    (valid && seen == CW'(DELAY)) |=> bits[BITS_W-1:1] == $past(bits[BITS_W-2:0])); // R6
  AST_NOW_LSB: assert property (@(posedge clk) disable iff (rst)
    valid |=> bit_now == bits[0]); // R7
endmodule

bind fsk_discriminator fsk_disc_checker #(.BITS_W(BITS_W), .DELAY(DELAY)) u_chk (
  .clk(clk), .rst(rst), .valid(sample_valid), .bits(bits_out), .bit_now(bit_now)
);

// File: tb/fsk_discriminator_test.sv
module fsk_discriminator_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_valid = 1'b0;
  logic signed [7:0] sample_in = '0;
  logic [7:0] bits_out;
  logic bit_now;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int hist [4];
  int m_cnt, m_x1, m_y1;
  logic [7:0] m_bits;

  fsk_discriminator uut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
    .bits_out(bits_out), .bit_now(bit_now)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 4; k++) hist[k] = 0;
    m_cnt = 0; m_x1 = 0; m_y1 = 0; m_bits = '0;
  endtask

  task automatic model_step(int s);
    int x, t, y;
    if (m_cnt < 4) begin
      m_cnt++;                                   // R3 fill only
    end else begin
      x = (s * hist[3]) >>> 2;                   // R4
      t = x + m_x1;
      y = sat16((t >>> 3) + (t >>> 5) + (t >>> 7) +
                (m_y1 >>> 1) + (m_y1 >>> 3) + (m_y1 >>> 5) + (m_y1 >>> 6)); // R5
      m_x1 = x; m_y1 = y;
      m_bits = {m_bits[6:0], (y > 0)};           // R6
    end
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = s;
  endtask

  task automatic check(string req, logic [7:0] exp);
    total++;
    if (bits_out !== exp || bit_now !== exp[0]) begin
      bad++;
      $display("FAIL %s: bits_out=%h bit_now=%b expected bits_out=%h bit_now=%b",
               req, bits_out, bit_now, exp, exp[0]);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with outputs checked.
  task automatic strobe(int s, string req);
    sample_valid = 1'b1;
    sample_in    = 8'(s);
    @(negedge clk);
    sample_valid = 1'b0;
    model_step(s);
    check(req, m_bits);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    check("R2 idle hold", m_bits);
  endtask

  task automatic reset_with_strobe(int s);
    rst = 1'b1;
    sample_valid = 1'b1;
    sample_in = 8'(s);
    @(negedge clk);
    rst = 1'b0;
    sample_valid = 1'b0;
    model_reset();
    check("R1 reset beats strobe", 8'h00);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 8'h00);

    // R3: fill strobes leave history at zero, R2 idle in between
    strobe(100, "R3 fill");
    idle(2);
    strobe(-90, "R3 fill");
    strobe(77, "R3 fill");
    strobe(-128, "R3 fill");
    // first filtered strobe right after fill boundary
    strobe(-128, "R4 first product");
    strobe(127, "R4 R5 extremes");
    strobe(-1, "R5 small");
    idle(5);

    // R8: period-4 input -> positive correlation
    reset_with_strobe(55);
    for (int k = 0; k < 4; k++) strobe((k < 2) ? 90 : -70, "R3 fill");
    for (int k = 0; k < 8; k++) strobe((k % 4 < 2) ? 90 : -70, "R6 periodic");
    check("R8 periodic gives all ones", 8'hFF);
    for (int k = 0; k < 16; k++) strobe((k % 8 < 4) ? 100 : -100, "R6 antiperiodic");
    check("R8 antiperiodic gives all zeros", 8'h00);

    // Random stimulus with gaps and occasional reset colliding with a strobe
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      int s = int'($urandom_range(0, 255)) - 128;
      if (r < 2) reset_with_strobe(s);
      else if (r < 12) idle(int'($urandom_range(1, 3)));
      else if (r < 16) strobe((r[0]) ? 127 : -128, "R5 corner");
      else strobe(s, "R4 R5 R6 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule